// File: doc/BRIEF.md
# Prioritized Interrupt Pending and Delivery Unit

This unit records interrupt requests for one processor thread and hands the thread the most urgent eligible request, one at a time. It has one bit per source for each of these: pending, delivered, manual-retract and edge-sensitive. Producers either raise a source, which records it and asks for an arbitration, or mark it, which only records it. A thread-side ready input and a global hold input decide when an outstanding arbitration may run. A delivery is reported on a registered strobe together with the source number and a trap-type code.

Each source is configured once, after reset. It can be made manual-retract, which means it stays pending until software retracts it. A manual source can then also be made edge-sensitive, which means it is delivered once and not again until it is retracted and raised afresh. The position of a source in the fixed list below is its priority.

Top module: `irq_deliver_unit`

## Requirements
- R1: After reset the unit has no pending source, the delivery strobe and the configuration error output are low, and every source is auto-retract and level-sensitive.
- R2: Sources are numbered 0 to 30 and a lower number always wins. The order is: 0 zero trap level, 1 inbound I/O fault, 2 performance event, 3 hypervisor tick match, 4 interrupt vector, 5 modular-arithmetic done, 6 control-word queue done, 7 hypervisor queue A, 8 processor mondo, 9 hypervisor queue B, 10 device mondo, 11 to 25 interrupt levels 15 down to 1, 26 recoverable software error, 27 I/O data-access error, 28 corrected hardware error, 29 resumable error, 30 non-resumable error. At most one source is delivered per check.
- R3: A raise for a source sets its pending bit and arms a check. A mark sets the pending bit only. An armed check runs at the first clock edge at which ready is high and hold is low, and it is consumed there whether or not a source is delivered. The delivery strobe is high for the one cycle after that edge.
- R4: Delivering an auto-retract source clears its pending bit at the delivery edge.
- R5: A manual-retract source stays pending after delivery. A retract of that source clears both its pending and delivered bits, and the retract takes effect even at a delivery edge. A raise or mark at the same edge as a retract leaves the source pending.
- R6: A level-sensitive manual source that is still pending is delivered again by any later check in which it is the highest-priority eligible source.
- R7: An edge-sensitive source whose delivered bit is set is skipped by arbitration, even when it is raised again. It becomes eligible again only after it is retracted and then raised.
- R8: The configuration port has two request kinds. Kind 0 makes a source manual-retract. Kind 1 makes a source edge-sensitive, but only if it is already manual. A kind-1 request on an auto-retract source is refused and pulses the error output for the one cycle after the request edge. Any raise, mark, retract or configuration request that names an index of 31 or above is ignored.
- R9: While hold is high, no source is delivered. Pending bits still accumulate, and an armed check stays armed.
- R10: Trap codes: sources 11 to 25 give 0x040 plus the interrupt level (0x04F down to 0x041). The others give 0:0x05F, 1:0x063, 2:0x05D, 3:0x05E, 4:0x060, 5:0x03D, 6:0x03C, 7:0x07A, 8:0x07C, 9:0x07B, 10:0x07D, 26:0x040, 27:0x032, 28:0x064, 29:0x078, 30:0x07F.
- R11: The any-pending output is the OR of all pending bits. The query output shows the pending bit of the queried index, and it is 0 for an index of 31 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_i | input | 1 | Record source and arm a check |
| mark_i | input | 1 | Record source only |
| src_idx_i | input | 5 | Source index for raise and mark |
| retract_i | input | 1 | Clear pending and delivered bits of a source |
| retract_idx_i | input | 5 | Source index for retract |
| cfg_wr_i | input | 1 | Configuration request |
| cfg_kind_i | input | 1 | 0 = make manual, 1 = make edge-sensitive |
| cfg_idx_i | input | 5 | Source index for configuration |
| cfg_err_o | output | 1 | Refused configuration pulse |
| hold_i | input | 1 | Global delivery hold |
| ready_i | input | 1 | Thread can accept a delivery |
| dlv_valid_o | output | 1 | Delivery strobe |
| dlv_idx_o | output | 5 | Delivered source |
| dlv_tt_o | output | 9 | Trap code of delivered source |
| any_pending_o | output | 1 | Some source pending |
| query_idx_i | input | 5 | Index to inspect |
| query_pending_o | output | 1 | Pending bit of queried index |

## Verification
The hardest state to reach is an edge-sensitive source that is pending and already delivered while an arbitration is armed. It only arises after a kind-0 request, then a kind-1 request, then a raise and a delivery, followed by a second raise. A directed sequence builds exactly that chain before a lower-priority raise arms a check. A long random phase then mixes holds, ready drops and retracts that land on delivery edges, and a behavioural model compares every output on every clock.

// File: rtl/irq_pkg.sv
// Package irq_pkg: shared constants and the fixed trap-code lookup for the
// interrupt delivery unit. Assumes source numbering follows priority order.
package irq_pkg;
    localparam int IRQ_SRC_N = 31;
    localparam int IRQ_TT_W  = 9;

    // Returns the trap code that the thread receives for a delivered source.
    function automatic logic [IRQ_TT_W-1:0] irq_tt_code(input int s);
        logic [IRQ_TT_W-1:0] c;
        if (s >= 11 && s <= 25) begin
            c = IRQ_TT_W'(9'h040 + 9'(26 - s));
        end else begin
            case (s)
                0:       c = 9'h05F;
                1:       c = 9'h063;
                2:       c = 9'h05D;
                3:       c = 9'h05E;
                4:       c = 9'h060;
                5:       c = 9'h03D;
                6:       c = 9'h03C;
                7:       c = 9'h07A;
                8:       c = 9'h07C;
                9:       c = 9'h07B;
                10:      c = 9'h07D;
                26:      c = 9'h040;
                27:      c = 9'h032;
                28:      c = 9'h064;
                29:      c = 9'h078;
                default: c = 9'h07F;
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/irq_src_bank.sv
// Module irq_src_bank: per-source pending, delivered, manual and edge bits.
// Assumes each input vector carries at most one bit per request kind and that
// dlv_vec is one-hot or zero. Set wins over clear for pending; retract wins
// over delivery for the delivered bit.
module irq_src_bank #(
    parameter int NUM_SRC = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] rtr_vec,
    input  logic [NUM_SRC-1:0] dlv_vec,
    input  logic [NUM_SRC-1:0] man_wr_vec,
    input  logic [NUM_SRC-1:0] edg_wr_vec,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] dlvd_q,
    output logic [NUM_SRC-1:0] man_q,
    output logic [NUM_SRC-1:0] edg_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Pending bit: set by raise/mark, cleared by retract or auto delivery.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= set_vec[i] |
                                     (pend_q[i] & ~rtr_vec[i] & ~(dlv_vec[i] & ~man_q[i]));
        end

        // Delivered bit: set on delivery, cleared by retract.
        always_ff @(posedge clk) begin
            if (!rst_n) dlvd_q[i] <= 1'b0;
            else        dlvd_q[i] <= (dlvd_q[i] | dlv_vec[i]) & ~rtr_vec[i];
        end

        // Configuration bits: manual is sticky, edge only on a manual source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                man_q[i] <= 1'b0;
                edg_q[i] <= 1'b0;
            end else begin
                if (man_wr_vec[i])             man_q[i] <= 1'b1;
                if (edg_wr_vec[i] && man_q[i]) edg_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module irq_prio_pick: fixed-priority picker, lowest set index wins.
// Assumes index 0 is the most urgent request.
module irq_prio_pick #(
    parameter int NUM_SRC = 31,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so that the lowest index is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_deliver_unit.sv
// Module irq_deliver_unit: tracks interrupt sources for one thread and delivers
// the most urgent eligible one when an armed check meets a ready, unheld thread.
// Assumes one raise/mark index, one retract and one configuration per cycle.
module irq_deliver_unit #(
    parameter int NUM_SRC = irq_pkg::IRQ_SRC_N,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int TT_W    = irq_pkg::IRQ_TT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_i,
    input  logic             mark_i,
    input  logic [IDX_W-1:0] src_idx_i,
    input  logic             retract_i,
    input  logic [IDX_W-1:0] retract_idx_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_kind_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    output logic             cfg_err_o,
    input  logic             hold_i,
    input  logic             ready_i,
    output logic             dlv_valid_o,
    output logic [IDX_W-1:0] dlv_idx_o,
    output logic [TT_W-1:0]  dlv_tt_o,
    output logic             any_pending_o,
    input  logic [IDX_W-1:0] query_idx_i,
    output logic             query_pending_o
);
    localparam logic [IDX_W:0] SRC_LIM = (IDX_W+1)'(NUM_SRC);

    logic               src_ok, rtr_ok, cfg_ok, qry_ok;
    logic [NUM_SRC-1:0] set_vec, rtr_vec, dlv_vec, man_wr_vec, edg_wr_vec;
    logic [NUM_SRC-1:0] pend_q, dlvd_q, man_q, edg_q, elig_vec;
    logic               chk_q, fire, pick_found, cfg_refuse;
    logic [IDX_W-1:0]   pick_idx;

    // Range checks on every incoming index.
    always_comb begin
        src_ok = {1'b0, src_idx_i}     < SRC_LIM;
        rtr_ok = {1'b0, retract_idx_i} < SRC_LIM;
        cfg_ok = {1'b0, cfg_idx_i}     < SRC_LIM;
        qry_ok = {1'b0, query_idx_i}   < SRC_LIM;
    end

    // Decode request indices into per-source strobes.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            set_vec[i]    = (raise_i | mark_i) & src_ok & (src_idx_i == IDX_W'(i));
            rtr_vec[i]    = retract_i & rtr_ok & (retract_idx_i == IDX_W'(i));
            man_wr_vec[i] = cfg_wr_i & ~cfg_kind_i & cfg_ok & (cfg_idx_i == IDX_W'(i));
            edg_wr_vec[i] = cfg_wr_i &  cfg_kind_i & cfg_ok & (cfg_idx_i == IDX_W'(i));
        end
    end

    irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .rtr_vec    (rtr_vec),
        .dlv_vec    (dlv_vec),
        .man_wr_vec (man_wr_vec),
        .edg_wr_vec (edg_wr_vec),
        .pend_q     (pend_q),
        .dlvd_q     (dlvd_q),
        .man_q      (man_q),
        .edg_q      (edg_q)
    );

    // Eligibility: pending and not an already-delivered edge source.
    assign elig_vec = pend_q & ~(edg_q & dlvd_q);

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req   (elig_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // A check runs when armed, the thread is ready and delivery is not held.
    assign fire = chk_q & ready_i & ~hold_i;

    // One-hot delivery vector for the bank.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            dlv_vec[i] = fire & pick_found & (pick_idx == IDX_W'(i));
    end

    // Check arming: a raise arms, a run consumes.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_q <= 1'b0;
        else        chk_q <= (raise_i & src_ok) | (chk_q & ~fire);
    end

    // Delivery outputs: strobe each cycle, index and code held between deliveries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid_o <= 1'b0;
            dlv_idx_o   <= '0;
            dlv_tt_o    <= '0;
        end else begin
            dlv_valid_o <= fire & pick_found;
            if (fire && pick_found) begin
                dlv_idx_o <= pick_idx;
                dlv_tt_o  <= irq_pkg::irq_tt_code(int'(pick_idx));
            end
        end
    end

    // Refused edge configuration on an auto-retract source.
    assign cfg_refuse = cfg_wr_i & cfg_kind_i & cfg_ok & ~(|(man_q & edg_wr_vec));

    // Configuration error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err_o <= 1'b0;
        else        cfg_err_o <= cfg_refuse;
    end

    // Status views of the pending bits.
    assign any_pending_o   = |pend_q;
    assign query_pending_o = qry_ok & |(pend_q & (NUM_SRC'(1) << query_idx_i));
endmodule

// File: rtl/irq_deliver_chk.sv
// Module irq_deliver_chk: temporal properties of the delivery unit, bound in.
// Assumes it sees the unit's eligibility vector from inside the top module.
module irq_deliver_chk #(
    parameter int NUM_SRC = 31,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready_i,
    input logic               hold_i,
    input logic               cfg_wr_i,
    input logic               cfg_kind_i,
    input logic               cfg_err_o,
    input logic               dlv_valid_o,
    input logic [IDX_W-1:0]   dlv_idx_o,
    input logic               any_pending_o,
    input logic [NUM_SRC-1:0] elig_vec
);
    localparam logic [IDX_W:0] SRC_LIM = (IDX_W+1)'(NUM_SRC);
    logic [NUM_SRC-1:0] below_mask, self_mask;

    // Masks of indices more urgent than, and equal to, the reported source.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            below_mask[i] = IDX_W'(i) < dlv_idx_o;
            self_mask[i]  = IDX_W'(i) == dlv_idx_o;
        end
    end

    AST_DLV_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> ({1'b0, dlv_idx_o} < SRC_LIM)); // R2
    AST_DLV_MOST_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> (($past(elig_vec) & below_mask) == '0)); // R2
    AST_DLV_WAS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> (($past(elig_vec) & self_mask) != '0)); // R7
    AST_DLV_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> $past(ready_i)); // R3
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_i) |-> !dlv_valid_o); // R9
    AST_CFG_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(cfg_wr_i && cfg_kind_i)); // R8
    AST_DLV_HAD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> $past(any_pending_o)); // R11
endmodule

bind irq_deliver_unit irq_deliver_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready_i       (ready_i),
    .hold_i        (hold_i),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_kind_i    (cfg_kind_i),
    .cfg_err_o     (cfg_err_o),
    .dlv_valid_o   (dlv_valid_o),
    .dlv_idx_o     (dlv_idx_o),
    .any_pending_o (any_pending_o),
    .elig_vec      (elig_vec)
);

// File: tb/sim_irq_deliver_unit.sv
// Bench for irq_deliver_unit: a behavioural model updated on every clock edge
// and compared with every output shortly after that edge.
module sim_irq_deliver_unit;
    localparam int N = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raise_i = 0, mark_i = 0, retract_i = 0, cfg_wr_i = 0, cfg_kind_i = 0;
    logic       hold_i = 0, ready_i = 1;
    logic [4:0] src_idx_i = 0, retract_idx_i = 0, cfg_idx_i = 0, query_idx_i = 0;
    logic       cfg_err_o, dlv_valid_o, any_pending_o, query_pending_o;
    logic [4:0] dlv_idx_o;
    logic [8:0] dlv_tt_o;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";

    // Model state.
    bit m_pend[N], m_dlvd[N], m_man[N], m_edg[N];
    bit m_chk, m_valid, m_err;
    int m_idx, m_tt;

    always #4 clk = ~clk;

    irq_deliver_unit u0 (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .mark_i(mark_i),
        .src_idx_i(src_idx_i), .retract_i(retract_i), .retract_idx_i(retract_idx_i),
        .cfg_wr_i(cfg_wr_i), .cfg_kind_i(cfg_kind_i), .cfg_idx_i(cfg_idx_i),
        .cfg_err_o(cfg_err_o), .hold_i(hold_i), .ready_i(ready_i),
        .dlv_valid_o(dlv_valid_o), .dlv_idx_o(dlv_idx_o), .dlv_tt_o(dlv_tt_o),
        .any_pending_o(any_pending_o), .query_idx_i(query_idx_i),
        .query_pending_o(query_pending_o)
    );

    // Trap codes as listed in R10.
    function automatic int tt_of(int s);
        int t [N] = '{'h05F, 'h063, 'h05D, 'h05E, 'h060, 'h03D, 'h03C, 'h07A, 'h07C,
                      'h07B, 'h07D, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                      'h040, 'h032, 'h064, 'h078, 'h07F};
        if (s >= 11 && s <= 25) return 'h040 + (26 - s);
        return t[s];
    endfunction

    task automatic chk(string what, string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s (%s) actual=%0h expected=%0h t=%0t", req, what, tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int pick = -1;
        bit fire;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0; m_dlvd[i] = 0; m_man[i] = 0; m_edg[i] = 0;
            end
            m_chk = 0; m_valid = 0; m_err = 0; m_idx = 0; m_tt = 0;
            return;
        end
        fire = m_chk && ready_i && !hold_i;
        if (fire)
            for (int i = 0; i < N; i++)
                if (pick < 0 && m_pend[i] && !(m_edg[i] && m_dlvd[i])) pick = i;
        m_valid = (pick >= 0);
        if (pick >= 0) begin
            m_idx = pick; m_tt = tt_of(pick);
            m_dlvd[pick] = 1;
            if (!m_man[pick]) m_pend[pick] = 0;
        end
        m_err = cfg_wr_i && cfg_kind_i && cfg_idx_i < N && !m_man[cfg_idx_i];
        if (retract_i && retract_idx_i < N) begin
            m_pend[retract_idx_i] = 0; m_dlvd[retract_idx_i] = 0;
        end
        if ((raise_i || mark_i) && src_idx_i < N) m_pend[src_idx_i] = 1;
        m_chk = (raise_i && src_idx_i < N) || (m_chk && !fire);
        if (cfg_wr_i && cfg_idx_i < N) begin
            if (!cfg_kind_i) m_man[cfg_idx_i] = 1;
            else if (m_man[cfg_idx_i]) m_edg[cfg_idx_i] = 1;
        end
    endtask

    task automatic compare_all();
        int anyp = 0;
        for (int i = 0; i < N; i++) anyp |= m_pend[i];
        chk("dlv_valid", "R3", dlv_valid_o, m_valid);
        if (m_valid) begin
            chk("dlv_idx", "R2", dlv_idx_o, m_idx);
            chk("dlv_tt", "R10", dlv_tt_o, m_tt);
        end
        chk("cfg_err", "R8", cfg_err_o, m_err);
        chk("any_pending", "R11", any_pending_o, anyp);
        chk("query_pending", "R11", query_pending_o, (query_idx_i < N) ? m_pend[query_idx_i] : 0);
    endtask

    // One clock: inputs are already driven; update model at the edge, compare after.
    task automatic step();
        @(posedge clk);
        model_edge();
        #3;
        compare_all();
        raise_i = 0; mark_i = 0; retract_i = 0; cfg_wr_i = 0;
    endtask

    task automatic do_raise(int s);   raise_i = 1; src_idx_i = 5'(s); query_idx_i = 5'(s); step(); endtask
    task automatic do_mark(int s);    mark_i = 1;  src_idx_i = 5'(s); step(); endtask
    task automatic do_retract(int s); retract_i = 1; retract_idx_i = 5'(s); step(); endtask
    task automatic do_cfg(int s, bit k); cfg_wr_i = 1; cfg_kind_i = k; cfg_idx_i = 5'(s); step(); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (%s)", tag);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        // R1: reset state.
        tag = "R1";
        idle(3);
        rst_n = 1;
        idle(2);
        for (int i = 0; i < N; i++) begin query_idx_i = 5'(i); idle(1); end

        // R2 and R3: marks do not arm, a raise picks the most urgent.
        tag = "R3"; do_mark(20); do_mark(5); idle(3);
        tag = "R2"; do_raise(25); idle(2); do_raise(30); idle(2); do_raise(0); idle(2);
        // R4: auto sources cleared; query shows.
        tag = "R4"; query_idx_i = 5; idle(1); query_idx_i = 20; idle(1);
        do_raise(20); idle(2);

        // R9: hold and ready gating with accumulation.
        tag = "R9"; hold_i = 1; do_raise(14); do_mark(3); do_raise(12); idle(3);
        hold_i = 0; ready_i = 0; idle(3); ready_i = 1; idle(3);
        do_raise(29); idle(2);

        // R5 and R6: manual level source redelivered, retract clears.
        tag = "R5"; do_cfg(4, 0); do_raise(4); idle(2);
        tag = "R6"; do_raise(18); idle(2); do_raise(18); idle(2);
        tag = "R5"; do_retract(4); do_raise(18); idle(2);
        do_raise(4); ready_i = 1; retract_i = 1; retract_idx_i = 4; step(); idle(2);
        do_raise(18); idle(2);

        // R8: refused edge configuration, out-of-range requests ignored.
        tag = "R8"; do_cfg(7, 1); idle(1); do_cfg(7, 0); do_cfg(7, 1); idle(1);
        do_cfg(31, 1); do_raise(31); do_mark(31); do_retract(31); idle(2);
        query_idx_i = 31; idle(1);

        // R7: edge source delivered once until retracted and raised again.
        tag = "R7"; do_raise(7); idle(2); do_raise(7); idle(2); do_raise(22); idle(2);
        do_retract(7); do_raise(7); idle(2); do_retract(7); do_retract(22); idle(2);

        // R2/R6: random stress against the model.
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            raise_i = ($urandom_range(0, 3) == 0);
            mark_i = ($urandom_range(0, 5) == 0);
            src_idx_i = 5'($urandom_range(0, 31));
            retract_i = ($urandom_range(0, 4) == 0);
            retract_idx_i = 5'($urandom_range(0, 31));
            cfg_wr_i = ($urandom_range(0, 40) == 0);
            cfg_kind_i = 1'($urandom_range(0, 1));
            cfg_idx_i = 5'($urandom_range(0, 31));
            hold_i = ($urandom_range(0, 7) == 0);
            ready_i = ($urandom_range(0, 5) != 0);
            query_idx_i = 5'($urandom_range(0, 31));
            step();
        end
        hold_i = 0; ready_i = 1; idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule